// File: doc/BRIEF.md
# SPI Master Transfer Engine with Run/Stop Sequencing

This block is a serial master that moves words from a transmit queue onto a serial data line and gathers the bits coming back into a receive queue. Each frame carries 4 to 16 bits, chosen per frame by a length input. The serial clock comes from a programmable divider of the system clock. A low-active select line frames each transfer.

A two-state run controller decides when frames may begin. The engine runs only while the end-of-queue flag is clear, the halt request is clear, and the freeze request is not honoured. The freeze request counts only while debug mode is active. When any stop cause appears with the engine idle, the engine stops on the next clock. If a frame is being shifted, the stop waits until that frame has finished. A status output reports the run state.

If the receive queue is full when a frame completes, the new word is discarded and a sticky overflow flag is raised. The words already stored are kept.

Top module: `spi_run_master`

## Requirements
- R1: While reset is high and after its release: `running`=0, `cs_n`=1, `sck`=0, `rx_empty`=1, `tx_full`=0 and `rx_ovf`=0.
- R2: From the stopped state, `running` becomes 1 on the next clock when `eoq_flag`=0, `halt_req`=0, and not (`debug_mode`=1 and `freeze_en`=1). `freeze_en` has no effect while `debug_mode`=0.
- R3: With no frame in progress (`cs_n`=1), a stop cause (`eoq_flag`=1, `halt_req`=1, or `debug_mode`=1 with `freeze_en`=1) clears `running` on the next clock.
- R4: A stop cause that appears during a frame leaves `running`=1 until the frame ends. `running` is still 1 in the cycle after `cs_n` returns high and is 0 one cycle later. No further frame starts while the stop cause persists.
- R5: A frame starts only while running with the transmit queue not empty. `cs_n` stays low for exactly 2·L·(D+1) system clocks, where L is the effective length and D is `clk_div`.
- R6: `sck` idles low whenever `cs_n`=1, and each of its phases lasts D+1 clocks. `mosi` carries the low L bits of the transmit word, most significant first. It changes only on falling `sck` edges and is valid at each rising edge.
- R7: `miso` is sampled on each rising `sck` edge. The L bits, first bit most significant and zero-extended to 16 bits, are written to the receive queue one clock after `cs_n` returns high.
- R8: The effective length L is `frame_len` clamped to the range 4..16. For example, 0 and 2 give 4, and 25 gives 16. L is captured when the frame starts.
- R9: When a frame completes with the receive queue full (4 words), that word is dropped and `rx_ovf` becomes 1 and stays 1 until reset. The stored words are read back unchanged.
- R10: Both queues are first-in first-out with 4 entries. `tx_full`=1 when 4 words are held, and a push while full is ignored. `rx_data` shows the oldest word while `rx_empty`=0, and `rx_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt request (stop cause) |
| eoq_flag | input | 1 | End-of-queue flag (stop cause) |
| debug_mode | input | 1 | Debug mode active |
| freeze_en | input | 1 | Freeze request, honoured only in debug mode |
| frame_len | input | 5 | Requested frame length in bits |
| clk_div | input | 4 | Serial clock half period minus one, in system clocks |
| tx_data | input | 16 | Word to enqueue for transmission |
| tx_push | input | 1 | Enqueue `tx_data` |
| tx_full | output | 1 | Transmit queue holds 4 words |
| rx_data | output | 16 | Oldest received word |
| rx_empty | output | 1 | Receive queue holds no word |
| rx_pop | input | 1 | Remove the oldest received word |
| running | output | 1 | 1 while running, 0 while stopped |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Frame select, active low |

## Verification
Run-state changes are due one clock after the input change, and the bench samples `running` on the next falling system clock edge. For a stop raised mid-frame, the bench samples `running` once in the cycle after `cs_n` is seen high and again one cycle later. Frame width is measured by counting falling system edges with `cs_n` low against 2·L·(D+1), and the bits on `mosi` are captured at rising `sck` edges. Because the received word is written one clock after `cs_n` rises, the bench reads `rx_data` one further falling edge after it first sees `cs_n` high.

// File: rtl/spi_run_pkg.sv
package spi_run_pkg;
  typedef enum logic {
    ST_STOPPED = 1'b0,
    ST_RUNNING = 1'b1
  } run_state_t;
endpackage

// File: rtl/spi_run_fifo.sv
module spi_run_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_run_ctrl.sv
module spi_run_ctrl
  import spi_run_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_cause,
  input  logic busy,
  output logic running
);
  run_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_STOPPED;
    end else begin
      case (state)
        ST_STOPPED: if (!stop_cause)         state <= ST_RUNNING;
        ST_RUNNING: if (stop_cause && !busy) state <= ST_STOPPED;
        default:                             state <= ST_STOPPED;
      endcase
    end
  end

  assign running = (state == ST_RUNNING);
endmodule

// File: rtl/spi_run_shifter.sv
module spi_run_shifter #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [LEN_W-1:0]  bits_left;
  logic [DIV_W-1:0]  cnt, div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      bits_left <= '0;
      cnt       <= '0;
      div_q     <= '0;
      busy      <= 1'b0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tx_sh     <= tx_word << (LEN_W'(DATA_W) - len);
        rx_sh     <= '0;
        bits_left <= len;
        cnt       <= '0;
        div_q     <= div;
        busy      <= 1'b1;
        sck       <= 1'b0;
        cs_n      <= 1'b0;
      end else if (busy) begin
        if (cnt == div_q) begin
          cnt <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
          end else begin
            sck       <= 1'b0;
            tx_sh     <= tx_sh << 1;
            bits_left <= bits_left - 1'b1;
            if (bits_left == LEN_W'(1)) begin
              busy <= 1'b0;
              cs_n <= 1'b1;
              done <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mosi    = tx_sh[DATA_W-1];
  assign rx_word = rx_sh;
endmodule

// File: rtl/spi_run_master.sv
module spi_run_master #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 4,
  parameter int DIV_W   = 4,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic              eoq_flag,
  input  logic              debug_mode,
  input  logic              freeze_en,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_push,
  output logic              tx_full,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_empty,
  input  logic              rx_pop,
  output logic              running,
  output logic              rx_ovf,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic              stop_cause, start, busy, done;
  logic              tx_empty, rx_full;
  logic [DATA_W-1:0] tx_head, rx_word;
  logic [LEN_W-1:0]  len_eff;

  assign stop_cause = eoq_flag || halt_req || (debug_mode && freeze_en);
  assign start      = running && !stop_cause && !tx_empty && !busy;

  always_comb begin
    if (frame_len < LEN_W'(MIN_LEN))     len_eff = LEN_W'(MIN_LEN);
    else if (frame_len > LEN_W'(DATA_W)) len_eff = LEN_W'(DATA_W);
    else                                 len_eff = frame_len;
  end

  spi_run_ctrl u_ctrl (
    .clk(clk), .rst(rst), .stop_cause(stop_cause), .busy(busy), .running(running)
  );

  spi_run_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_data), .pop(start),
    .rdata(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spi_run_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_head), .len(len_eff),
    .div(clk_div), .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .done(done), .rx_word(rx_word)
  );

  spi_run_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(done && !rx_full), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_data), .empty(rx_empty), .full(rx_full)
  );

  always_ff @(posedge clk) begin
    if (rst)                  rx_ovf <= 1'b0;
    else if (done && rx_full) rx_ovf <= 1'b1;
  end
endmodule

// File: rtl/spi_run_checker.sv
module spi_run_checker (
  input logic clk,
  input logic rst,
  input logic halt_req,
  input logic eoq_flag,
  input logic debug_mode,
  input logic freeze_en,
  input logic running,
  input logic cs_n,
  input logic sck,
  input logic rx_ovf
);
  logic stop_seen;
  assign stop_seen = halt_req | eoq_flag | (debug_mode & freeze_en);

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!running && !stop_seen) |=> running);

  p_stop_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (running && stop_seen && cs_n) |=> !running);

  p_hold_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (running && !cs_n) |=> running);

  p_no_frame_stopped_r5: assert property (@(posedge clk) disable iff (rst)
    (!running && cs_n) |=> cs_n);

  p_sck_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    rx_ovf |=> rx_ovf);
endmodule

bind spi_run_master spi_run_checker u_chk (
  .clk(clk), .rst(rst), .halt_req(halt_req), .eoq_flag(eoq_flag),
  .debug_mode(debug_mode), .freeze_en(freeze_en), .running(running),
  .cs_n(cs_n), .sck(sck), .rx_ovf(rx_ovf)
);

// File: tb/spi_run_master_test.sv
module spi_run_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt_req = 1'b0, eoq_flag = 1'b0, debug_mode = 1'b0, freeze_en = 1'b0;
  logic [4:0]  frame_len = 5'd8;
  logic [3:0]  clk_div = 4'd0;
  logic [15:0] tx_data = '0;
  logic        tx_push = 1'b0, rx_pop = 1'b0;
  logic        tx_full, rx_empty, running, rx_ovf, sck, mosi, miso, cs_n;
  logic [15:0] rx_data;
  logic        inv = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [15:0] dec;
  int nb;

  always #4 clk = ~clk;

  assign miso = inv ? ~mosi : mosi;

  spi_run_master uut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .eoq_flag(eoq_flag),
    .debug_mode(debug_mode), .freeze_en(freeze_en), .frame_len(frame_len),
    .clk_div(clk_div), .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full),
    .rx_data(rx_data), .rx_empty(rx_empty), .rx_pop(rx_pop), .running(running),
    .rx_ovf(rx_ovf), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always @(posedge sck or negedge cs_n) begin
    if (!sck) begin
      dec <= '0;
      nb  <= 0;
    end else begin
      dec <= {dec[14:0], mosi};
      nb  <= nb + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w);
    tx_data = w;
    tx_push = 1'b1;
    tick();
    tx_push = 1'b0;
  endtask

  task automatic pop_check(input string req, input int exp);
    chk(req, rx_empty, 0);
    chk(req, rx_data, exp);
    rx_pop = 1'b1;
    tick();
    rx_pop = 1'b0;
  endtask

  task automatic wait_cs_low();
    for (int i = 0; i < 400 && cs_n; i++) tick();
  endtask

  task automatic run_frame(input logic [15:0] w, input int len, input int div,
                           input logic iv, input int eff);
    int n = 0;
    int mask = (1 << eff) - 1;
    frame_len = 5'(len);
    clk_div   = 4'(div);
    inv       = iv;
    push(w);
    wait_cs_low();
    while (!cs_n && n < 1000) begin
      n++;
      tick();
    end
    chk("R5 frame width", n, 2 * eff * (div + 1));
    chk("R6 mosi bits", int'(dec), int'(w) & mask);
    chk("R6 bit count", nb, eff);
    tick();
    pop_check("R7 rx word", iv ? (int'(~w) & mask) : (int'(w) & mask));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowcnt;
    logic bad;
    repeat (3) tick();
    // R1: reset state
    chk("R1 running", running, 0);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sck", sck, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_ovf", rx_ovf, 0);
    halt_req = 1'b1;
    rst = 1'b0;
    tick();
    chk("R1 stopped after reset", running, 0);

    // R2 / R3 start and idle stop
    halt_req = 1'b0; tick();
    chk("R2 start", running, 1);
    eoq_flag = 1'b1; tick();
    chk("R3 eoq stop", running, 0);
    eoq_flag = 1'b0; debug_mode = 1'b1; tick();
    chk("R2 debug without freeze", running, 1);
    freeze_en = 1'b1; tick();
    chk("R3 freeze stop", running, 0);
    debug_mode = 1'b0; tick();
    chk("R2 freeze ignored outside debug", running, 1);
    freeze_en = 1'b0;
    halt_req = 1'b1; tick();
    chk("R3 halt stop", running, 0);
    halt_req = 1'b0; tick();

    // R5 R6 R7 sweep over lengths and dividers
    for (int d = 0; d < 3; d++)
      for (int l = 4; l <= 16; l++)
        run_frame(16'((l * 16'h1357 + d * 16'h0F0F + 16'h5A3C) & 16'hFFFF),
                  l, d, l[0], l);

    // R8 clamping
    run_frame(16'hABCD, 2, 1, 1'b0, 4);
    run_frame(16'h1234, 0, 0, 1'b1, 4);
    run_frame(16'hC3A5, 25, 0, 1'b0, 16);

    // R10 and R5: queue fills while halted, no frame while stopped
    frame_len = 5'd8; clk_div = 4'd0; inv = 1'b0;
    halt_req = 1'b1; tick();
    chk("R3 halted", running, 0);
    for (int i = 0; i < 4; i++) push(16'(8'h11 * (i + 1)));
    chk("R10 tx_full", tx_full, 1);
    push(16'h00EE);
    bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!cs_n) bad = 1'b1;
      tick();
    end
    chk("R5 no frame while stopped", bad, 0);
    halt_req = 1'b0;
    repeat (120) tick();
    chk("R10 tx drained", tx_full, 0);
    for (int i = 0; i < 4; i++) pop_check("R10 order", 8'h11 * (i + 1));
    chk("R10 extra push dropped", rx_empty, 1);

    // R9 overflow
    for (int i = 0; i < 4; i++) push(16'(8'h21 + i));
    repeat (120) tick();
    chk("R9 no overflow yet", rx_ovf, 0);
    push(16'h00FF);
    repeat (40) tick();
    chk("R9 overflow flag", rx_ovf, 1);
    for (int i = 0; i < 4; i++) pop_check("R9 stored words", 8'h21 + i);
    chk("R9 dropped word", rx_empty, 1);
    repeat (5) tick();
    chk("R9 sticky", rx_ovf, 1);

    // R4 deferred stop during a frame
    frame_len = 5'd16; clk_div = 4'd2;
    push(16'hA55A);
    push(16'h0FF0);
    wait_cs_low();
    repeat (10) tick();
    halt_req = 1'b1;
    bad = 1'b0;
    lowcnt = 0;
    while (!cs_n && lowcnt < 1000) begin
      if (!running) bad = 1'b1;
      lowcnt++;
      tick();
    end
    chk("R4 running held during frame", bad, 0);
    chk("R4 running after frame end", running, 1);
    tick();
    chk("R4 stopped one clock later", running, 0);
    bad = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (!cs_n) bad = 1'b1;
      tick();
    end
    chk("R4 no new frame while stopped", bad, 0);
    halt_req = 1'b0;
    repeat (120) tick();
    pop_check("R4 first word", 16'hA55A);
    pop_check("R4 second word", 16'h0FF0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule